// File: doc/BRIEF.md
# ALU Status Flag Generator

This block forms the result and the next status byte for the 8-bit arithmetic and logic operations of a small processor core. It takes two operands, an operation code and the current status byte, and produces the result together with the updated half-carry, sign, overflow, negative, zero and carry flags. The interrupt-enable and bit-store flags travel through untouched. The operation path is purely combinational.

A status register inside the block captures the computed status byte on a clock edge whenever the update enable is high. The core can then feed that register back as the current status byte. The carry-chained subtract and compare codes combine the old zero flag with the new one. A sequence of byte-wide compares therefore reports equality of a whole multi-byte value.

Top module: `alu_flag_unit`

## Requirements
- R1: Status bit 7 (interrupt enable) and bit 6 (bit store) of `stat_nxt` always equal the same bits of `stat_cur`. The remaining bits are: 5 half carry, 4 sign, 3 overflow, 2 negative, 1 zero, 0 carry.
- R2: Code 0 (add) gives `opa + opb`, and code 1 (add with carry) gives `opa + opb + C`, both modulo 256. C is the carry out of bit 7, H is the carry out of bit 3, and V is set when the signed sum overflows.
- R3: Code 2 (subtract) and code 4 (compare) give `opa - opb`. Code 3 (subtract with carry) and code 5 (compare with carry) give `opa - opb - C`. C is set on a borrow out of bit 7, H on a borrow out of bit 3, and V on a signed overflow.
- R4: For codes 0 to 9, N equals bit 7 of the result and S equals N XOR V.
- R5: For codes 0, 1, 2, 4 and 6 to 9, Z is set exactly when the result is zero.
- R6: For codes 3 and 5, Z is set only when the result is zero and the incoming Z is set. Otherwise Z is cleared.
- R7: The logic codes are 6 (AND), 7 (OR), 8 (XOR) and 9 (test, result = `opa`). They clear V and leave C and H at their incoming values.
- R8: Codes 10 to 15 return `opa` as the result, and `stat_nxt` equals `stat_cur`.
- R9: `stat_q` is 0 after a synchronous reset. It loads `stat_nxt` on a rising clock edge when `upd_en` is high and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Loads the status register at the next edge |
| op_code | input | 4 | Operation select |
| opa | input | 8 | Destination operand |
| opb | input | 8 | Source operand or immediate |
| stat_cur | input | 8 | Current status byte |
| result | output | 8 | Operation result |
| stat_nxt | output | 8 | Computed status byte |
| stat_q | output | 8 | Registered status byte |

## Verification
The flag properties are sampled at the rising edge. They assume that `op_code`, the operands and `stat_cur` hold settled, known values there and that `upd_en` is low while reset is asserted. The stimulus keeps to this by changing every input only at the falling edge and by holding `upd_en` at zero through reset. Because the combinational checks are taken at every edge, each operand pattern the tasks apply is seen by the properties as well.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int STAT_W = 8;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_CPC = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_EOR = 4'd8,
        OP_TST = 4'd9
    } alu_op_e;

    // Field order follows the status byte, bit 7 first.
    typedef struct packed {
        logic irq_en;
        logic bit_store;
        logic half;
        logic sign;
        logic ovf;
        logic neg;
        logic zero;
        logic carry;
    } stat_s;

    function automatic logic op_is_arith(input logic [3:0] op);
        return op <= OP_CPC;
    endfunction

    function automatic logic op_is_sub(input logic [3:0] op);
        return (op >= OP_SUB) && (op <= OP_CPC);
    endfunction

    function automatic logic op_uses_carry(input logic [3:0] op);
        return (op == OP_ADC) || (op == OP_SBC) || (op == OP_CPC);
    endfunction

    function automatic logic op_chains_zero(input logic [3:0] op);
        return (op == OP_SBC) || (op == OP_CPC);
    endfunction

    function automatic logic op_is_logic(input logic [3:0] op);
        return (op >= OP_AND) && (op <= OP_TST);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W   = 8,
    parameter int HALF_BIT = 3
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              h_out,
    output logic              v_out
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] cin_ext;
    logic [DATA_W-1:0] cy_vec;
    logic [DATA_W-1:0] ov_vec;

    assign cin_ext = {{(DATA_W-1){1'b0}}, cin};

    always_comb begin
        if (sub) begin
            res    = a - b - cin_ext;
            cy_vec = (~a & b) | (b & res) | (res & ~a);
            ov_vec = (a & ~b & ~res) | (~a & b & res);
        end else begin
            res    = a + b + cin_ext;
            cy_vec = (a & b) | (b & ~res) | (~res & a);
            ov_vec = (a & b & ~res) | (~a & ~b & res);
        end
    end

    assign c_out = cy_vec[MSB];
    assign h_out = cy_vec[HALF_BIT];
    assign v_out = ov_vec[MSB];

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    import alu_flag_pkg::*;

    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_EOR:  res = a ^ b;
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu_stat_reg.sv
module alu_stat_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
    parameter int DATA_W   = 8,
    parameter int HALF_BIT = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             upd_en,
    input  logic [3:0]                       op_code,
    input  logic [DATA_W-1:0]                opa,
    input  logic [DATA_W-1:0]                opb,
    input  logic [alu_flag_pkg::STAT_W-1:0]  stat_cur,
    output logic [DATA_W-1:0]                result,
    output logic [alu_flag_pkg::STAT_W-1:0]  stat_nxt,
    output logic [alu_flag_pkg::STAT_W-1:0]  stat_q
);
    import alu_flag_pkg::*;

    localparam int MSB = DATA_W - 1;

    stat_s             cur;
    stat_s             nxt;
    logic              as_cin;
    logic [DATA_W-1:0] as_res;
    logic              as_c;
    logic              as_h;
    logic              as_v;
    logic [DATA_W-1:0] lg_res;

    assign cur    = stat_s'(stat_cur);
    assign as_cin = op_uses_carry(op_code) ? cur.carry : 1'b0;

    alu_addsub #(
        .DATA_W   (DATA_W),
        .HALF_BIT (HALF_BIT)
    ) addsub_i (
        .a     (opa),
        .b     (opb),
        .cin   (as_cin),
        .sub   (op_is_sub(op_code)),
        .res   (as_res),
        .c_out (as_c),
        .h_out (as_h),
        .v_out (as_v)
    );

    alu_logic #(
        .DATA_W (DATA_W)
    ) logic_i (
        .op  (op_code),
        .a   (opa),
        .b   (opb),
        .res (lg_res)
    );

    always_comb begin
        nxt    = cur;
        result = opa;
        if (op_is_arith(op_code)) begin
            result    = as_res;
            nxt.carry = as_c;
            nxt.half  = as_h;
            nxt.ovf   = as_v;
            nxt.neg   = as_res[MSB];
            nxt.sign  = as_res[MSB] ^ as_v;
            nxt.zero  = (as_res == '0) &&
                        (op_chains_zero(op_code) ? cur.zero : 1'b1);
        end else if (op_is_logic(op_code)) begin
            result    = lg_res;
            nxt.ovf   = 1'b0;
            nxt.neg   = lg_res[MSB];
            nxt.sign  = lg_res[MSB];
            nxt.zero  = (lg_res == '0);
        end
    end

    assign stat_nxt = nxt;

    alu_stat_reg #(
        .WIDTH (STAT_W)
    ) stat_reg_i (
        .clk (clk),
        .rst (rst),
        .en  (upd_en),
        .d   (stat_nxt),
        .q   (stat_q)
    );

endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              upd_en,
    input logic [3:0]        op_code,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic [7:0]        stat_cur,
    input logic [DATA_W-1:0] result,
    input logic [7:0]        stat_nxt,
    input logic [7:0]        stat_q
);
    // R1
    it_pass_chk: assert property (@(posedge clk) disable iff (rst)
        stat_nxt[7:6] == stat_cur[7:6]);

    // R2
    add_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'd0) |->
        ({stat_nxt[0], result} == ({1'b0, opa} + {1'b0, opb})));

    // R4
    sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code <= 4'd9) |->
        ((stat_nxt[4] == (stat_nxt[3] ^ stat_nxt[2])) &&
         (stat_nxt[2] == result[DATA_W-1])));

    // R6
    chain_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (((op_code == 4'd3) || (op_code == 4'd5)) && !stat_cur[1]) |->
        !stat_nxt[1]);

    // R7
    logic_keep_chk: assert property (@(posedge clk) disable iff (rst)
        ((op_code >= 4'd6) && (op_code <= 4'd9)) |->
        (!stat_nxt[3] && (stat_nxt[5] == stat_cur[5]) &&
         (stat_nxt[0] == stat_cur[0])));

    // R8
    undef_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code > 4'd9) |-> ((stat_nxt == stat_cur) && (result == opa)));

    // R9
    reg_load_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> (stat_q == $past(stat_nxt)));

    // R9
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(stat_q));

endmodule

bind alu_flag_unit alu_flag_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .upd_en   (upd_en),
    .op_code  (op_code),
    .opa      (opa),
    .opb      (opb),
    .stat_cur (stat_cur),
    .result   (result),
    .stat_nxt (stat_nxt),
    .stat_q   (stat_q)
);

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       upd_en = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] opa = 8'd0;
    logic [7:0] opb = 8'd0;
    logic [7:0] stat_cur = 8'd0;
    logic [7:0] result;
    logic [7:0] stat_nxt;
    logic [7:0] stat_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    alu_flag_unit dut_i (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (upd_en),
        .op_code  (op_code),
        .opa      (opa),
        .opb      (opb),
        .stat_cur (stat_cur),
        .result   (result),
        .stat_nxt (stat_nxt),
        .stat_q   (stat_q)
    );

    // Expected {result, status} from the requirements.
    function automatic logic [15:0] model(input logic [3:0] op,
                                          input logic [7:0] a,
                                          input logic [7:0] b,
                                          input logic [7:0] f);
        int ci;
        int ra;
        logic [7:0] r;
        logic [7:0] nf;
        nf = f;
        r  = a;
        ci = ((op == 4'd1) || (op == 4'd3) || (op == 4'd5)) ? int'(f[0]) : 0;
        if (op <= 4'd1) begin
            ra    = int'(a) + int'(b) + ci;
            r     = ra[7:0];
            nf[0] = (ra > 255);
            nf[5] = ((int'(a) % 16) + (int'(b) % 16) + ci) > 15;
            nf[3] = (a[7] == b[7]) && (r[7] != a[7]);
        end else if (op <= 4'd5) begin
            ra    = int'(a) - int'(b) - ci;
            r     = ra[7:0];
            nf[0] = (ra < 0);
            nf[5] = (int'(a) % 16) < ((int'(b) % 16) + ci);
            nf[3] = (a[7] != b[7]) && (r[7] != a[7]);
        end else if (op <= 4'd9) begin
            case (op)
                4'd6:    r = a & b;
                4'd7:    r = a | b;
                4'd8:    r = a ^ b;
                default: r = a;
            endcase
            nf[3] = 1'b0;
        end
        if (op <= 4'd9) begin
            nf[2] = r[7];
            nf[4] = nf[2] ^ nf[3];
            nf[1] = (r == 8'd0) &&
                    (((op == 4'd3) || (op == 4'd5)) ? f[1] : 1'b1);
        end
        return {r, nf};
    endfunction

    task automatic check8(input string tag, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // Apply at the falling edge, compare the combinational outputs.
    task automatic apply(input string tag, input logic [3:0] op,
                         input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] f);
        logic [15:0] e;
        @(negedge clk);
        op_code  = op;
        opa      = a;
        opb      = b;
        stat_cur = f;
        #1;
        e = model(op, a, b, f);
        check8(tag, "result", result, e[15:8]);
        check8(tag, "status", stat_nxt, e[7:0]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check8("R9", "stat_q after reset", stat_q, 8'h00);
    endtask

    task automatic t_add();
        apply("R2", 4'd0, 8'h7F, 8'h01, 8'h00);
        apply("R2", 4'd0, 8'hFF, 8'h01, 8'h00);
        apply("R2", 4'd0, 8'h0F, 8'h01, 8'h00);
        apply("R2", 4'd0, 8'h80, 8'h80, 8'h00);
        apply("R2", 4'd1, 8'h10, 8'h20, 8'h01);
        apply("R2", 4'd1, 8'hFE, 8'h01, 8'h01);
    endtask

    task automatic t_sub();
        apply("R3", 4'd2, 8'h00, 8'h01, 8'h00);
        apply("R3", 4'd2, 8'h80, 8'h01, 8'h00);
        apply("R3", 4'd2, 8'h10, 8'h01, 8'h00);
        apply("R5", 4'd2, 8'h42, 8'h42, 8'h00);
        apply("R3", 4'd4, 8'h05, 8'h09, 8'h00);
        apply("R3", 4'd3, 8'h20, 8'h1F, 8'h01);
    endtask

    task automatic t_chain_zero();
        apply("R6", 4'd3, 8'h05, 8'h04, 8'h03);
        apply("R6", 4'd3, 8'h05, 8'h04, 8'h01);
        apply("R6", 4'd5, 8'h33, 8'h33, 8'h02);
        apply("R6", 4'd5, 8'h33, 8'h33, 8'h00);
        apply("R6", 4'd5, 8'h34, 8'h33, 8'h02);
    endtask

    task automatic t_logic();
        apply("R7", 4'd6, 8'hF0, 8'h0F, 8'h29);
        apply("R7", 4'd7, 8'h80, 8'h01, 8'h08);
        apply("R7", 4'd8, 8'hAA, 8'hAA, 8'h21);
        apply("R7", 4'd9, 8'h9C, 8'h00, 8'h09);
        apply("R4", 4'd9, 8'h00, 8'hFF, 8'h3F);
    endtask

    task automatic t_passthru();
        for (int op = 0; op < 10; op++) begin
            apply("R1", op[3:0], 8'h5A, 8'hC3, 8'hC0 ^ op[7:0]);
        end
    endtask

    task automatic t_undef();
        for (int op = 10; op < 16; op++) begin
            apply("R8", op[3:0], 8'h3C + op[7:0], 8'h01, 8'hA5);
        end
    endtask

    task automatic t_register();
        logic [15:0] e;
        e = model(4'd2, 8'h00, 8'h01, 8'h40);
        @(negedge clk);
        op_code = 4'd2; opa = 8'h00; opb = 8'h01; stat_cur = 8'h40;
        upd_en  = 1'b1;
        @(negedge clk);
        upd_en  = 1'b0;
        check8("R9", "stat_q load", stat_q, e[7:0]);
        op_code = 4'd0; opa = 8'h01; opb = 8'h01; stat_cur = 8'h00;
        repeat (3) @(negedge clk);
        check8("R9", "stat_q hold", stat_q, e[7:0]);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_add();
        t_sub();
        t_chain_zero();
        t_logic();
        t_passthru();
        t_undef();
        t_register();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule